// File: doc/BRIEF.md
# Dual-Clock Two-Lane Shared RAM with Per-Port Read Latency

This block is a synchronous RAM that two independent agents reach at once. Each side has its own clock, its own address and data buses, and its own set of controls. Both sides see one shared word array. A word is split into equal lanes. Each lane can be read or written on its own through an active-low lane select.

Each side can choose its own read latency. In flow-through mode, read data appears right after the edge that samples the request. In pipelined mode, one extra register stage delays it by one cycle. That register stage also delays the effect of a deselect by one cycle. There are no tri-state drivers. Each side presents its read data together with one valid flag per lane; a lane that is not valid drives zero.

Each side runs a small access state machine. It has three states: ACC_IDLE, ACC_READ and ACC_WRITE. On every rising edge it moves to one of them:
- ACC_READ when the port is selected, the read/write pin is high and at least one lane is selected.
- ACC_WRITE when the port is selected, the pin is low and at least one lane is selected.
- ACC_IDLE in all other cases.

Any state can move to any state, and the decision does not depend on the current state. A second register copies the first one edge later, and it drives the pipelined output.

Top module: `dpram_dual_mode`

## Requirements
- R1: A port takes part in an access only when its active-low enable is 0 and its active-high enable is 1. In any other case, no lane is written and, in flow-through mode, no lane is flagged valid after that edge. Out of reset no lane is flagged valid.
- R2: The read/write pin is sampled on the rising edge: 1 requests a read and 0 requests a write.
- R3: Lane-select bit 0 (active low) governs the lower lane, data bits [LANE_W-1:0], and bit 1 governs the upper lane. Each lane is read or written independently of the other. With both bits at 1, nothing is accessed and a write leaves the stored word unchanged.
- R4: While the active-low output enable is 1, every valid flag is 0 and the read data is 0, in either latency mode, without waiting for a clock.
- R5: In flow-through mode (mode pin 0), a read sampled at edge k shows the selected lanes valid with the stored data from edge k until edge k+1.
- R6: In pipelined mode (mode pin 1), the same read shows from edge k+1 until edge k+2.
- R7: In pipelined mode, a deselect at edge k+1 that follows a read at edge k still presents that read until edge k+2. Two deselected edges in a row leave no lane valid.
- R8: An edge that performs a write flags none of the written lanes valid in the output slot that belongs to it: after edge k in flow-through mode, after edge k+1 in pipelined mode.
- R9: A word written through either port is read back unchanged through the other port.
- R10: When both ports write the same address on the same edge, each lane written by port B takes port B's value. A lane written by port A alone takes port A's value.
- R11: A lane that is not flagged valid drives zero on its read data bits, while the other lane shows its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pa_clk | input | 1 | Port A clock |
| pa_rst_n | input | 1 | Port A asynchronous reset, active low |
| pa_addr | input | ADDR_W | Port A word address |
| pa_wdata | input | LANE_W*LANES | Port A write data |
| pa_ce_n | input | 1 | Port A enable, active low |
| pa_ce | input | 1 | Port A enable, active high |
| pa_rw | input | 1 | Port A read (1) or write (0) |
| pa_lane_n | input | LANES | Port A lane selects, active low |
| pa_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| pa_pipe | input | 1 | Port A latency mode: 1 pipelined, 0 flow-through |
| pa_rdata | output | LANE_W*LANES | Port A read data, zero on invalid lanes |
| pa_rvld | output | LANES | Port A per-lane valid flags |
| pb_clk | input | 1 | Port B clock |
| pb_rst_n | input | 1 | Port B asynchronous reset, active low |
| pb_addr | input | ADDR_W | Port B word address |
| pb_wdata | input | LANE_W*LANES | Port B write data |
| pb_ce_n | input | 1 | Port B enable, active low |
| pb_ce | input | 1 | Port B enable, active high |
| pb_rw | input | 1 | Port B read (1) or write (0) |
| pb_lane_n | input | LANES | Port B lane selects, active low |
| pb_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| pb_pipe | input | 1 | Port B latency mode: 1 pipelined, 0 flow-through |
| pb_rdata | output | LANE_W*LANES | Port B read data, zero on invalid lanes |
| pb_rvld | output | LANES | Port B per-lane valid flags |

## Verification
The latency properties rest on two assumptions:
- The mode pin and output enable are read at the same sampling point as the valid flags, so a mode change between request and result simply releases the check.
- The collision rule for same-address writes assumes both ports share one clock edge, as they do in the bench.

The random stimulus drives both ports from one clock and draws new inputs only at falling edges. Whenever one port would write the word that the other port reads on the same edge, the writer is turned into a reader. This keeps every checked read free of a same-cycle cross-port write.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Access recorded by a port on a rising edge.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

endpackage

// File: rtl/dpr_shared_store.sv
// Shared word array reached from two clock domains. Each port writes only
// its own bank and its own ownership bits; a lane reads from the bank whose
// owner bits say it was written last.
module dpr_shared_store #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int ADDR_W = 6,
    localparam int WORD_W = LANE_W * LANES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk_a,
    input  logic              wr_a_en,
    input  logic [ADDR_W-1:0] wr_a_addr,
    input  logic [WORD_W-1:0] wr_a_data,
    input  logic [LANES-1:0]  wr_a_mask,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic              clk_b,
    input  logic              wr_b_en,
    input  logic [ADDR_W-1:0] wr_b_addr,
    input  logic [WORD_W-1:0] wr_b_data,
    input  logic [LANES-1:0]  wr_b_mask,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [WORD_W-1:0] rd_b_data
);

    logic [WORD_W-1:0] bank_a [DEPTH];
    logic [WORD_W-1:0] bank_b [DEPTH];
    logic [LANES-1:0]  own_a  [DEPTH];
    logic [LANES-1:0]  own_b  [DEPTH];

    // Port B claims a lane by making the owner bits differ, port A by making
    // them equal. Port A yields a lane that port B writes on the same edge.
    logic [LANES-1:0] clash_a;
    assign clash_a = (wr_b_en && (wr_b_addr == wr_a_addr)) ? wr_b_mask : '0;

    always_ff @(posedge clk_a) begin
        if (wr_a_en) begin
            for (int j = 0; j < LANES; j++) begin
                if (wr_a_mask[j]) begin
                    bank_a[wr_a_addr][j*LANE_W +: LANE_W] <= wr_a_data[j*LANE_W +: LANE_W];
                    if (!clash_a[j]) begin
                        own_a[wr_a_addr][j] <= own_b[wr_a_addr][j];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_b) begin
        if (wr_b_en) begin
            for (int j = 0; j < LANES; j++) begin
                if (wr_b_mask[j]) begin
                    bank_b[wr_b_addr][j*LANE_W +: LANE_W] <= wr_b_data[j*LANE_W +: LANE_W];
                    own_b[wr_b_addr][j] <= ~own_a[wr_b_addr][j];
                end
            end
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane_rd
        assign rd_a_data[j*LANE_W +: LANE_W] =
            (own_a[rd_a_addr][j] == own_b[rd_a_addr][j]) ?
                bank_a[rd_a_addr][j*LANE_W +: LANE_W] :
                bank_b[rd_a_addr][j*LANE_W +: LANE_W];
        assign rd_b_data[j*LANE_W +: LANE_W] =
            (own_a[rd_b_addr][j] == own_b[rd_b_addr][j]) ?
                bank_a[rd_b_addr][j*LANE_W +: LANE_W] :
                bank_b[rd_b_addr][j*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/dpr_port_ctrl.sv
// One port: decodes the pins into an access, keeps a two-stage record of
// accesses and selects the flow-through or pipelined view for the outputs.
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int ADDR_W = 6,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              rw,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_mask,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  rvld
);

    logic [LANES-1:0] lane_en;
    logic             sel;
    logic             any_lane;

    if (LANES == 1) begin : g_single
        assign lane_en = '1;
    end else begin : g_multi
        assign lane_en = ~lane_n;
    end

    assign sel      = !ce_n && ce;
    assign any_lane = |lane_en;

    // Stage 1: access taken on the latest edge; stage 2: the one before.
    acc_e              s1_state, s1_next, s2_state;
    logic [LANES-1:0]  s1_lanes, s2_lanes;
    logic [ADDR_W-1:0] s1_addr;
    logic [WORD_W-1:0] s2_data;

    always_comb begin
        if (!sel || !any_lane) begin
            s1_next = ACC_IDLE;
        end else if (rw) begin
            s1_next = ACC_READ;
        end else begin
            s1_next = ACC_WRITE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_state <= ACC_IDLE;
            s2_state <= ACC_IDLE;
            s1_lanes <= '0;
            s2_lanes <= '0;
            s1_addr  <= '0;
            s2_data  <= '0;
        end else begin
            s1_state <= s1_next;
            s1_lanes <= lane_en;
            s1_addr  <= addr;
            s2_state <= s1_state;
            s2_lanes <= s1_lanes;
            s2_data  <= mem_rdata;
        end
    end

    assign wr_en   = (s1_next == ACC_WRITE);
    assign wr_addr = addr;
    assign wr_data = wdata;
    assign wr_mask = lane_en;
    assign rd_addr = s1_addr;

    logic [LANES-1:0]  ft_vld, pp_vld, vld_sel;
    logic [WORD_W-1:0] data_src;

    always_comb begin
        unique case (s1_state)
            ACC_READ:             ft_vld = s1_lanes;
            ACC_IDLE, ACC_WRITE:  ft_vld = '0;
            default:              ft_vld = '0;
        endcase
        unique case (s2_state)
            ACC_READ:             pp_vld = s2_lanes;
            ACC_IDLE, ACC_WRITE:  pp_vld = '0;
            default:              pp_vld = '0;
        endcase
        vld_sel  = oe_n ? '0 : (pipe ? pp_vld : ft_vld);
        data_src = pipe ? s2_data : mem_rdata;
    end

    assign rvld = vld_sel;
    for (genvar j = 0; j < LANES; j++) begin : g_lane_out
        assign rdata[j*LANE_W +: LANE_W] = vld_sel[j] ? data_src[j*LANE_W +: LANE_W] : '0;
    end

    // R1: a deselected edge in flow-through mode leaves nothing valid
    p_desel_ft_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && !sel) |=> (pipe || rvld == '0));

    // R5: flow-through read is visible in the cycle after its edge
    p_ft_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && sel && rw && any_lane) |=> (pipe || oe_n || rvld == $past(lane_en)));

    // R6: pipelined read is visible one cycle later
    p_pipe_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rw && any_lane) |=> ##1 (!pipe || oe_n || rvld == $past(lane_en, 2)));

    // R7: two deselected edges clear the pipelined view
    p_pipe_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) ##1 (!sel) |=> (!pipe || rvld == '0));

    // R8: full-word writes never show valid lanes in either view
    p_write_quiet_ft_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rw && lane_en == '1) |=> (pipe || rvld == '0));
    p_write_quiet_pp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rw && lane_en == '1) |=> ##1 (!pipe || rvld == '0));

endmodule

// File: rtl/dpram_dual_mode.sv
module dpram_dual_mode
    import dpr_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int ADDR_W = 6,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              pa_clk,
    input  logic              pa_rst_n,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic [WORD_W-1:0] pa_wdata,
    input  logic              pa_ce_n,
    input  logic              pa_ce,
    input  logic              pa_rw,
    input  logic [LANES-1:0]  pa_lane_n,
    input  logic              pa_oe_n,
    input  logic              pa_pipe,
    output logic [WORD_W-1:0] pa_rdata,
    output logic [LANES-1:0]  pa_rvld,
    input  logic              pb_clk,
    input  logic              pb_rst_n,
    input  logic [ADDR_W-1:0] pb_addr,
    input  logic [WORD_W-1:0] pb_wdata,
    input  logic              pb_ce_n,
    input  logic              pb_ce,
    input  logic              pb_rw,
    input  logic [LANES-1:0]  pb_lane_n,
    input  logic              pb_oe_n,
    input  logic              pb_pipe,
    output logic [WORD_W-1:0] pb_rdata,
    output logic [LANES-1:0]  pb_rvld
);

    logic              a_wr_en, b_wr_en;
    logic [ADDR_W-1:0] a_wr_addr, b_wr_addr, a_rd_addr, b_rd_addr;
    logic [WORD_W-1:0] a_wr_data, b_wr_data, a_mem, b_mem;
    logic [LANES-1:0]  a_wr_mask, b_wr_mask;

    dpr_port_ctrl #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_port_a (
        .clk(pa_clk), .rst_n(pa_rst_n), .addr(pa_addr), .wdata(pa_wdata),
        .ce_n(pa_ce_n), .ce(pa_ce), .rw(pa_rw), .lane_n(pa_lane_n),
        .oe_n(pa_oe_n), .pipe(pa_pipe), .mem_rdata(a_mem),
        .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data), .wr_mask(a_wr_mask),
        .rd_addr(a_rd_addr), .rdata(pa_rdata), .rvld(pa_rvld)
    );

    dpr_port_ctrl #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_port_b (
        .clk(pb_clk), .rst_n(pb_rst_n), .addr(pb_addr), .wdata(pb_wdata),
        .ce_n(pb_ce_n), .ce(pb_ce), .rw(pb_rw), .lane_n(pb_lane_n),
        .oe_n(pb_oe_n), .pipe(pb_pipe), .mem_rdata(b_mem),
        .wr_en(b_wr_en), .wr_addr(b_wr_addr), .wr_data(b_wr_data), .wr_mask(b_wr_mask),
        .rd_addr(b_rd_addr), .rdata(pb_rdata), .rvld(pb_rvld)
    );

    dpr_shared_store #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_store (
        .clk_a(pa_clk), .wr_a_en(a_wr_en), .wr_a_addr(a_wr_addr), .wr_a_data(a_wr_data),
        .wr_a_mask(a_wr_mask), .rd_a_addr(a_rd_addr), .rd_a_data(a_mem),
        .clk_b(pb_clk), .wr_b_en(b_wr_en), .wr_b_addr(b_wr_addr), .wr_b_data(b_wr_data),
        .wr_b_mask(b_wr_mask), .rd_b_addr(b_rd_addr), .rd_b_data(b_mem)
    );

endmodule

// File: tb/dpram_dual_mode_bench.sv
module dpram_dual_mode_bench;

    localparam int LW = 9;
    localparam int LN = 2;
    localparam int AW = 6;
    localparam int WW = LW * LN;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic pa_ce_n, pa_ce, pa_rw, pa_oe_n, pa_pipe;
    logic pb_ce_n, pb_ce, pb_rw, pb_oe_n, pb_pipe;
    logic [LN-1:0] pa_lane_n, pb_lane_n, pa_rvld, pb_rvld;
    logic [AW-1:0] pa_addr, pb_addr;
    logic [WW-1:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;

    dpram_dual_mode #(.LANE_W(LW), .LANES(LN), .ADDR_W(AW)) u_dpram_dual_mode (
        .pa_clk(clk), .pa_rst_n(rst_n), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
        .pa_ce_n(pa_ce_n), .pa_ce(pa_ce), .pa_rw(pa_rw), .pa_lane_n(pa_lane_n),
        .pa_oe_n(pa_oe_n), .pa_pipe(pa_pipe), .pa_rdata(pa_rdata), .pa_rvld(pa_rvld),
        .pb_clk(clk), .pb_rst_n(rst_n), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_ce_n(pb_ce_n), .pb_ce(pb_ce), .pb_rw(pb_rw), .pb_lane_n(pb_lane_n),
        .pb_oe_n(pb_oe_n), .pb_pipe(pb_pipe), .pb_rdata(pb_rdata), .pb_rvld(pb_rvld)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string force_tag = "";

    logic [WW-1:0] model [DEPTH];
    // Per-port history: access kind (0 none, 1 read, 2 write), lanes, data.
    int            hk1 [2];
    int            hk2 [2];
    logic [LN-1:0] hl1 [2];
    logic [LN-1:0] hl2 [2];
    logic [WW-1:0] hd1 [2];
    logic [WW-1:0] hd2 [2];

    function automatic logic [WW-1:0] pat(input int a);
        return WW'((a * 2371 + 77) ^ 18'h2_5A5A);
    endfunction

    function automatic logic [WW-1:0] lane_mask_data(input logic [LN-1:0] v, input logic [WW-1:0] d);
        logic [WW-1:0] r;
        for (int j = 0; j < LN; j++) r[j*LW +: LW] = v[j] ? d[j*LW +: LW] : '0;
        return r;
    endfunction

    task automatic set_op(input int p, input int kind, input logic [LN-1:0] ln,
                          input logic [AW-1:0] a, input logic [WW-1:0] d);
        logic cen, cee;
        cen = 1'b0;
        cee = 1'b1;
        if (kind == 0) begin
            if ($urandom % 2 == 0) cen = 1'b1; else cee = 1'b0;
        end
        if (p == 0) begin
            pa_ce_n = cen; pa_ce = cee; pa_rw = (kind != 2);
            pa_lane_n = ln; pa_addr = a; pa_wdata = d;
        end else begin
            pb_ce_n = cen; pb_ce = cee; pb_rw = (kind != 2);
            pb_lane_n = ln; pb_addr = a; pb_wdata = d;
        end
    endtask

    task automatic check_port(input int p);
        logic oe, pp;
        logic [LN-1:0] v, ev, l;
        logic [WW-1:0] dt, ed, d;
        int k;
        string tag;
        oe = (p == 0) ? pa_oe_n : pb_oe_n;
        pp = (p == 0) ? pa_pipe : pb_pipe;
        v  = (p == 0) ? pa_rvld : pb_rvld;
        dt = (p == 0) ? pa_rdata : pb_rdata;
        k  = pp ? hk2[p] : hk1[p];
        l  = pp ? hl2[p] : hl1[p];
        d  = pp ? hd2[p] : hd1[p];
        ev = (!oe && k == 1) ? l : '0;
        ed = lane_mask_data(ev, d);
        if (force_tag != "") tag = force_tag;
        else if (oe) tag = "R4";
        else if (k == 0) tag = "R1";
        else if (k == 2) tag = "R8";
        else if (pp) tag = "R6";
        else tag = "R5";
        n_tests++;
        if (v !== ev || dt !== ed) begin
            n_fail++;
            $display("FAIL %s port %0d: vld=%b data=%h expected vld=%b data=%h",
                     tag, p, v, dt, ev, ed);
        end
    endtask

    task automatic tick();
        logic          s  [2];
        logic          rw [2];
        logic [LN-1:0] le [2];
        logic [AW-1:0] ad [2];
        logic [WW-1:0] wd [2];
        @(posedge clk);
        s[0] = !pa_ce_n && pa_ce;  rw[0] = pa_rw; le[0] = ~pa_lane_n; ad[0] = pa_addr; wd[0] = pa_wdata;
        s[1] = !pb_ce_n && pb_ce;  rw[1] = pb_rw; le[1] = ~pb_lane_n; ad[1] = pb_addr; wd[1] = pb_wdata;
        // port A first, then port B: B wins a shared lane (R10)
        for (int p = 0; p < 2; p++) begin
            if (s[p] && !rw[p]) begin
                for (int j = 0; j < LN; j++)
                    if (le[p][j]) model[ad[p]][j*LW +: LW] = wd[p][j*LW +: LW];
            end
        end
        for (int p = 0; p < 2; p++) begin
            hk2[p] = hk1[p]; hl2[p] = hl1[p]; hd2[p] = hd1[p];
            hk1[p] = (!s[p] || le[p] == '0) ? 0 : (rw[p] ? 1 : 2);
            hl1[p] = le[p];
            hd1[p] = model[ad[p]];
        end
        @(negedge clk);
        check_port(0);
        check_port(1);
    endtask

    task automatic idle_both();
        set_op(0, 0, 2'b11, '0, '0);
        set_op(1, 0, 2'b11, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        pa_oe_n = 1'b0; pb_oe_n = 1'b0; pa_pipe = 1'b0; pb_pipe = 1'b0;
        idle_both();
        for (int p = 0; p < 2; p++) begin
            hk1[p] = 0; hk2[p] = 0; hl1[p] = '0; hl2[p] = '0; hd1[p] = '0; hd2[p] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        n_tests++;
        if (pa_rvld !== '0 || pb_rvld !== '0 || pa_rdata !== '0 || pb_rdata !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: vld=%b/%b expected 00/00", pa_rvld, pb_rvld);
        end
        rst_n = 1'b1;
        tick();

        // preload every word through port A
        for (int a = 0; a < DEPTH; a++) begin
            set_op(0, 2, 2'b00, AW'(a), pat(a));
            set_op(1, 0, 2'b11, '0, '0);
            tick();
        end

        // R9: B reads what A wrote, then A reads what B wrote
        force_tag = "R9";
        for (int a = 0; a < 6; a++) begin
            set_op(0, 0, 2'b11, '0, '0);
            set_op(1, 1, 2'b00, AW'(a), '0);
            tick();
        end
        for (int a = 8; a < 12; a++) begin
            set_op(0, 0, 2'b11, '0, '0);
            set_op(1, 2, 2'b00, AW'(a), WW'(18'h3_0000 + a));
            tick();
        end
        for (int a = 8; a < 12; a++) begin
            set_op(0, 1, 2'b00, AW'(a), '0);
            set_op(1, 0, 2'b11, '0, '0);
            tick();
        end

        // R2: write then read back the same word
        force_tag = "R2";
        set_op(1, 0, 2'b11, '0, '0);
        set_op(0, 2, 2'b00, 6'd20, 18'h1_2345); tick();
        set_op(0, 1, 2'b00, 6'd20, 18'h0_0000); tick();

        // R3: lower-only, upper-only and no-lane writes
        force_tag = "R3";
        set_op(0, 2, 2'b10, 6'd21, 18'h3_FFFF); tick();
        set_op(0, 2, 2'b01, 6'd22, 18'h3_FFFF); tick();
        set_op(0, 2, 2'b11, 6'd23, 18'h3_FFFF); tick();
        for (int a = 21; a < 24; a++) begin
            set_op(0, 1, 2'b00, AW'(a), '0); tick();
        end

        // R11: single-lane read, other lane must drive zero
        force_tag = "R11";
        set_op(0, 1, 2'b01, 6'd5, '0); tick();
        set_op(0, 1, 2'b10, 6'd6, '0); tick();

        // R1: deselected write must not change the word
        force_tag = "R1";
        set_op(0, 0, 2'b00, 6'd7, '0); pa_rw = 1'b0; pa_wdata = 18'h0_0BAD; tick();
        set_op(0, 1, 2'b00, 6'd7, '0); tick();

        // R6: pipelined reads on A
        force_tag = "R6";
        idle_both(); pa_pipe = 1'b1; tick();
        for (int a = 30; a < 34; a++) begin
            set_op(0, 1, 2'b00, AW'(a), '0); tick();
        end
        idle_both(); tick(); tick();

        // R7: pipelined read followed by deselects on B
        force_tag = "R7";
        pb_pipe = 1'b1;
        set_op(1, 1, 2'b00, 6'd35, '0); tick();
        set_op(1, 0, 2'b00, 6'd36, '0); tick();
        set_op(1, 0, 2'b00, 6'd37, '0); tick();
        tick();

        // R4: output enable high blanks both modes
        force_tag = "R4";
        pa_oe_n = 1'b1; pb_oe_n = 1'b1; pa_pipe = 1'b0;
        set_op(0, 1, 2'b00, 6'd40, '0);
        set_op(1, 1, 2'b00, 6'd41, '0);
        tick(); tick(); tick();
        pa_oe_n = 1'b0; pb_oe_n = 1'b0; pb_pipe = 1'b0;
        idle_both(); tick();

        // R10: both ports write the same word on one edge
        force_tag = "R10";
        set_op(0, 2, 2'b00, 6'd44, 18'h1_5555);
        set_op(1, 2, 2'b10, 6'd44, 18'h0_0AAA);
        tick();
        set_op(0, 2, 2'b10, 6'd45, 18'h0_0111);
        set_op(1, 2, 2'b01, 6'd45, 18'h3_FE00);
        tick();
        set_op(0, 1, 2'b00, 6'd44, '0);
        set_op(1, 1, 2'b00, 6'd45, '0);
        tick();
        idle_both(); tick();

        // random mix on both ports
        force_tag = "";
        for (int c = 0; c < 3000; c++) begin
            int kd [2];
            logic [LN-1:0] ln [2];
            logic [AW-1:0] ad [2];
            logic [WW-1:0] wd [2];
            for (int p = 0; p < 2; p++) begin
                int r;
                r = int'($urandom % 10);
                kd[p] = (r < 2) ? 0 : ((r < 6) ? 1 : 2);
                ln[p] = LN'($urandom % 4);
                if ($urandom % 3 != 0) ln[p] = 2'b00;
                ad[p] = AW'($urandom);
                wd[p] = WW'($urandom);
            end
            if (ad[0] == ad[1]) begin
                if (kd[0] == 2 && kd[1] == 1) kd[0] = 1;
                if (kd[1] == 2 && kd[0] == 1) kd[1] = 1;
            end
            if ($urandom % 16 == 0) pa_pipe = ~pa_pipe;
            if ($urandom % 16 == 0) pb_pipe = ~pb_pipe;
            pa_oe_n = ($urandom % 8 == 0);
            pb_oe_n = ($urandom % 8 == 0);
            set_op(0, kd[0], ln[0], ad[0], wd[0]);
            set_op(1, kd[1], ln[1], ad[1], wd[1]);
            tick();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule